// File: doc/BRIEF.md
# Checkpoint-Tagged Write Log Buffer

This block sits beside a small cache array and keeps enough history to roll the array back to a validated checkpoint. Each line holds data, a coherence state and a checkpoint tag. The tag records the interval in which the line was last written, filled or given away. The first store, fill or ownership transfer that touches a line in the current interval appends the line's prior contents to a log FIFO. Any later change to the same line within that interval is not logged, because recovery only ever returns to an interval boundary.

Three pulse inputs drive the checkpoint sequence. `ckpt_new` opens a new interval. `validate` moves the recovery point forward by one interval. Log entries recorded before the new recovery point are then retired from the head of the FIFO, one per cycle, in the background. `recover` unwinds the log from its newest end. It writes each saved line back until only entries older than the recovery point would remain. It then empties the log and restarts the active interval at the recovery point. A line that was filled during an unvalidated interval goes back to its earlier contents, which makes it invalid again. The array is read combinationally at `op_addr`, and loads use that same path.

Top module: `ckpt_log_buffer`

## Requirements
- R1: After reset the active interval is 1, the recovery point is 1, the log is empty, `op_ready` is high, and every line reads data 0, state 0 and tag 0.
- R2: An accepted store (kind 1), transfer-out (kind 2) or fill (kind 3) to a line whose tag differs from the active interval adds one log entry. The line's tag then equals the active interval.
- R3: An accepted store, transfer-out or fill to a line whose tag already equals the active interval leaves the log count unchanged.
- R4: A load (kind 0) never changes the log count, nor the line's data, state or tag.
- R5: A transfer-out sets the line's state to 0 (invalid) and keeps its data. A store or fill writes `op_data` and `op_state`.
- R6: A `ckpt_new` pulse raises the active interval by one.
- R7: `log_full` is high when the count equals LOG_DEPTH. While it is high, `op_ready` is low for an operation that needs a log entry and high for one that does not. A stalled operation changes nothing.
- R8: A `validate` pulse raises the recovery point by one, unless it already equals the active interval; in that case the pulse is ignored. Entries logged in intervals before the recovery point are then retired from the head, one per cycle.
- R9: A `recover` pulse raises `recovering` from the next cycle. While `recovering` is high, `op_ready` is low. The log is replayed newest first, restoring data, state and tag. At the end the log is empty and the active interval equals the recovery point.
- R10: After recovery, every line matches its contents at the start of the recovery-point interval. A line filled after that point returns to state 0.
- R11: After recovery, the first store to a restored line is logged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 0 load, 1 store, 2 transfer-out, 3 fill |
| op_addr | input | ADDR_W | Line index, also the read address |
| op_data | input | DATA_W | Data for a store or fill |
| op_state | input | ST_W | New coherence state for a store or fill |
| ckpt_new | input | 1 | Open a new checkpoint interval |
| validate | input | 1 | Advance the recovery point by one |
| recover | input | 1 | Roll back to the recovery point |
| op_ready | output | 1 | Operation can be accepted this cycle |
| rd_data | output | DATA_W | Data of line `op_addr` |
| rd_state | output | ST_W | State of line `op_addr` |
| rd_cn | output | CN_W | Checkpoint tag of line `op_addr` |
| active_cn | output | CN_W | Active interval number |
| recov_cn | output | CN_W | Recovery point interval number |
| log_count | output | $clog2(LOG_DEPTH)+1 | Entries held in the log |
| log_full | output | 1 | Log holds LOG_DEPTH entries |
| recovering | output | 1 | Rollback in progress |

## Verification
The hardest case to reach from the ports is a rollback in which the log still holds entries from several intervals, with the same line logged in more than one of them. Only that case shows whether the newest-first order leaves the oldest saved value in place. The stimulus builds it in steps. It fills the log until it stalls, then validates so that some entries retire in the background. It then logs the same lines again in a later interval and triggers recovery. The restored array is compared with a copy the bench took when the recovery-point interval opened.

// File: rtl/ckpt_log_buffer.sv
module ckpt_log_buffer #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int ST_W      = 2,
  parameter int CN_W      = 8,
  parameter int LOG_DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           op_valid,
  input  logic [1:0]                     op_kind,
  input  logic [ADDR_W-1:0]              op_addr,
  input  logic [DATA_W-1:0]              op_data,
  input  logic [ST_W-1:0]                op_state,
  input  logic                           ckpt_new,
  input  logic                           validate,
  input  logic                           recover,
  output logic                           op_ready,
  output logic [DATA_W-1:0]              rd_data,
  output logic [ST_W-1:0]                rd_state,
  output logic [CN_W-1:0]                rd_cn,
  output logic [CN_W-1:0]                active_cn,
  output logic [CN_W-1:0]                recov_cn,
  output logic [$clog2(LOG_DEPTH):0]     log_count,
  output logic                           log_full,
  output logic                           recovering
);
  localparam int LINES = 1 << ADDR_W;
  localparam int PTR_W = $clog2(LOG_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [1:0] K_LOAD = 2'd0;
  localparam logic [1:0] K_XFER = 2'd2;

  logic [DATA_W-1:0] ln_data [LINES];
  logic [ST_W-1:0]   ln_st   [LINES];
  logic [CN_W-1:0]   ln_cn   [LINES];

  logic [ADDR_W-1:0] lg_addr [LOG_DEPTH];
  logic [DATA_W-1:0] lg_data [LOG_DEPTH];
  logic [ST_W-1:0]   lg_st   [LOG_DEPTH];
  logic [CN_W-1:0]   lg_cn   [LOG_DEPTH];
  logic [CN_W-1:0]   lg_iv   [LOG_DEPTH];

  logic [PTR_W-1:0] wr_ptr, rd_ptr, tail, wr_nxt, rd_nxt;
  logic [CNT_W-1:0] cnt;
  logic [CN_W-1:0]  act, rcv, head_age, tail_age;
  logic             rec;

  assign rd_data    = ln_data[op_addr];
  assign rd_state   = ln_st[op_addr];
  assign rd_cn      = ln_cn[op_addr];
  assign active_cn  = act;
  assign recov_cn   = rcv;
  assign log_count  = cnt;
  assign recovering = rec;

  wire writes   = op_kind != K_LOAD;
  wire need_log = writes && (ln_cn[op_addr] != act);
  assign log_full = cnt == CNT_W'(LOG_DEPTH);
  assign op_ready = !rec && !recover && !(need_log && log_full);
  wire accept = op_valid && op_ready;
  wire push   = accept && need_log;

  assign wr_nxt = (wr_ptr == PTR_W'(LOG_DEPTH-1)) ? '0 : wr_ptr + 1'b1;
  assign rd_nxt = (rd_ptr == PTR_W'(LOG_DEPTH-1)) ? '0 : rd_ptr + 1'b1;
  assign tail   = (wr_ptr == '0) ? PTR_W'(LOG_DEPTH-1) : wr_ptr - 1'b1;

  assign head_age = lg_iv[rd_ptr] - rcv;
  assign tail_age = lg_iv[tail] - rcv;
  wire retire    = !rec && (cnt != '0) && head_age[CN_W-1];
  wire tail_keep = (cnt != '0) && !tail_age[CN_W-1];
  wire restore   = rec && tail_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      act    <= CN_W'(1);
      rcv    <= CN_W'(1);
      rec    <= 1'b0;
    end else if (rec) begin
      if (tail_keep) begin
        wr_ptr <= tail;
        cnt    <= cnt - 1'b1;
      end else begin
        rec    <= 1'b0;
        cnt    <= '0;
        rd_ptr <= wr_ptr;
        act    <= rcv;
      end
    end else begin
      if (recover) rec <= 1'b1;
      else begin
        if (ckpt_new) act <= act + 1'b1;
        if (validate && rcv != act) rcv <= rcv + 1'b1;
      end
      if (push)   wr_ptr <= wr_nxt;
      if (retire) rd_ptr <= rd_nxt;
      cnt <= cnt + CNT_W'(push) - CNT_W'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      lg_addr[wr_ptr] <= op_addr;
      lg_data[wr_ptr] <= ln_data[op_addr];
      lg_st[wr_ptr]   <= ln_st[op_addr];
      lg_cn[wr_ptr]   <= ln_cn[op_addr];
      lg_iv[wr_ptr]   <= act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        ln_data[i] <= '0;
        ln_st[i]   <= '0;
        ln_cn[i]   <= '0;
      end
    end else if (restore) begin
      ln_data[lg_addr[tail]] <= lg_data[tail];
      ln_st[lg_addr[tail]]   <= lg_st[tail];
      ln_cn[lg_addr[tail]]   <= lg_cn[tail];
    end else if (accept && writes) begin
      ln_cn[op_addr] <= act;
      if (op_kind == K_XFER) ln_st[op_addr] <= '0;
      else begin
        ln_data[op_addr] <= op_data;
        ln_st[op_addr]   <= op_state;
      end
    end
  end
endmodule

// File: rtl/ckpt_log_buffer_chk.sv
module ckpt_log_buffer_chk #(
  parameter int CN_W      = 8,
  parameter int LOG_DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       op_valid,
  input logic [1:0]                 op_kind,
  input logic                       op_ready,
  input logic [CN_W-1:0]            rd_cn,
  input logic [CN_W-1:0]            active_cn,
  input logic [CN_W-1:0]            recov_cn,
  input logic [$clog2(LOG_DEPTH):0] log_count,
  input logic                       log_full,
  input logic                       recovering
);
  wire [CN_W-1:0] gap = active_cn - recov_cn;

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_count <= ($clog2(LOG_DEPTH)+1)'(LOG_DEPTH));

  // R9
  stall_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> !op_ready);

  // R4
  load_no_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind == 2'd0) |=> log_count <= $past(log_count));

  // R3
  repeat_no_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind != 2'd0 && rd_cn == active_cn)
      |=> log_count <= $past(log_count));

  // R2
  first_write_logs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_kind != 2'd0 && rd_cn != active_cn)
      |=> log_count != '0);

  // R8
  recov_not_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gap[CN_W-1]);

  // R9
  recovery_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recovering) |-> (log_count == '0 && active_cn == recov_cn));
endmodule

bind ckpt_log_buffer ckpt_log_buffer_chk #(.CN_W(CN_W), .LOG_DEPTH(LOG_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_ready(op_ready), .rd_cn(rd_cn), .active_cn(active_cn),
  .recov_cn(recov_cn), .log_count(log_count), .log_full(log_full),
  .recovering(recovering));

// File: tb/ckpt_log_buffer_test.sv
module ckpt_log_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3, DW = 16, SW = 2, CW = 6, DEPTH = 4;
  localparam int LINES = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, ckpt_new = 0, validate = 0, recover = 0;
  logic [1:0] op_kind = 0;
  logic [AW-1:0] op_addr = 0;
  logic [DW-1:0] op_data = 0;
  logic [SW-1:0] op_state = 0;
  logic op_ready, log_full, recovering;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] rd_state;
  logic [CW-1:0] rd_cn, active_cn, recov_cn;
  logic [$clog2(DEPTH):0] log_count;

  int checks = 0, errors = 0;
  logic [DW-1:0] gold_d [LINES];
  logic [SW-1:0] gold_s [LINES];
  logic [DW-1:0] mdl_d [LINES];
  logic [SW-1:0] mdl_s [LINES];

  ckpt_log_buffer #(.ADDR_W(AW), .DATA_W(DW), .ST_W(SW), .CN_W(CW), .LOG_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_state(op_state), .ckpt_new(ckpt_new), .validate(validate),
    .recover(recover), .op_ready(op_ready), .rd_data(rd_data), .rd_state(rd_state),
    .rd_cn(rd_cn), .active_cn(active_cn), .recov_cn(recov_cn), .log_count(log_count),
    .log_full(log_full), .recovering(recovering));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input int a);
    op_addr = AW'(a);
    #1;
  endtask

  task automatic do_op(input int kind, input int a, input int d, input int s);
    @(negedge clk);
    op_valid = 1; op_kind = 2'(kind); op_addr = AW'(a); op_data = DW'(d); op_state = SW'(s);
    if (kind == 1 || kind == 3) begin mdl_d[a] = DW'(d); mdl_s[a] = SW'(s); end
    if (kind == 2) mdl_s[a] = '0;
    @(negedge clk);
    op_valid = 0;
    #1;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) ckpt_new = 1; else if (which == 1) validate = 1; else recover = 1;
    @(negedge clk);
    ckpt_new = 0; validate = 0; recover = 0;
    #1;
  endtask

  task automatic t_reset;
    chk(active_cn == 1, "R1 active", active_cn, 1);
    chk(recov_cn == 1, "R1 recovery point", recov_cn, 1);
    chk(log_count == 0, "R1 count", log_count, 0);
    chk(op_ready == 1, "R1 ready", op_ready, 1);
    for (int i = 0; i < LINES; i++) begin
      peek(i);
      chk(rd_data == 0 && rd_state == 0 && rd_cn == 0, "R1 line", rd_data, 0);
    end
  endtask

  task automatic t_first_and_repeat;
    do_op(1, 2, 'h1111, 3);
    peek(2);
    chk(log_count == 1, "R2 first store logged", log_count, 1);
    chk(rd_cn == 1, "R2 tag updated", rd_cn, 1);
    chk(rd_data == 'h1111 && rd_state == 3, "R5 store writes", rd_data, 'h1111);
    do_op(1, 2, 'h2222, 3);
    chk(log_count == 1, "R3 repeat store not logged", log_count, 1);
    do_op(0, 2, 'h9999, 1);
    peek(2);
    chk(log_count == 1, "R4 load count", log_count, 1);
    chk(rd_data == 'h2222 && rd_state == 3 && rd_cn == 1, "R4 load leaves line", rd_data, 'h2222);
  endtask

  task automatic t_fill_xfer;
    do_op(3, 3, 'h3333, 1);
    chk(log_count == 2, "R2 fill logged", log_count, 2);
    do_op(2, 3, 0, 0);
    peek(3);
    chk(log_count == 2, "R3 transfer same interval", log_count, 2);
    chk(rd_state == 0 && rd_data == 'h3333, "R5 transfer invalidates", rd_state, 0);
  endtask

  task automatic t_ckpt_and_full;
    for (int i = 0; i < LINES; i++) begin gold_d[i] = mdl_d[i]; gold_s[i] = mdl_s[i]; end
    pulse(0);
    chk(active_cn == 2, "R6 new interval", active_cn, 2);
    do_op(1, 2, 'h4444, 2);
    chk(log_count == 3, "R2 new interval relogs", log_count, 3);
    do_op(1, 4, 'h5555, 2);
    chk(log_count == 4 && log_full, "R7 full", log_count, 4);
    @(negedge clk);
    op_valid = 1; op_kind = 1; op_addr = 5; op_data = 'hbad; op_state = 1;
    #1;
    chk(op_ready == 0, "R7 stall needing log", op_ready, 0);
    @(negedge clk);
    op_valid = 0;
    peek(5);
    chk(rd_data == 0 && log_count == 4, "R7 stalled op no effect", rd_data, 0);
    op_kind = 1; peek(2);
    chk(op_ready == 1, "R7 no-log op proceeds", op_ready, 1);
    do_op(1, 2, 'h6666, 2);
    chk(log_count == 4, "R3 store while full", log_count, 4);
  endtask

  task automatic t_validate;
    pulse(1);
    chk(recov_cn == 2, "R8 recovery point advanced", recov_cn, 2);
    repeat (5) @(negedge clk);
    #1;
    chk(log_count == 2 && !log_full, "R8 old entries retired", log_count, 2);
    pulse(1);
    chk(recov_cn == 2, "R8 validate of active ignored", recov_cn, 2);
  endtask

  task automatic t_recover;
    do_op(3, 5, 'h7777, 1);
    chk(log_count == 3, "R2 fill in interval 2", log_count, 3);
    pulse(0);
    do_op(1, 4, 'h8888, 3);
    chk(log_count == 4, "R2 interval 3 logs", log_count, 4);
    pulse(2);
    chk(recovering == 1 && op_ready == 0, "R9 recovering stalls", recovering, 1);
    for (int k = 0; k < 20 && recovering; k++) @(negedge clk);
    #1;
    chk(!recovering, "R9 recovery ends", recovering, 0);
    chk(log_count == 0, "R9 log empty", log_count, 0);
    chk(active_cn == 2, "R9 active reset to recovery point", active_cn, 2);
    for (int i = 0; i < LINES; i++) begin
      peek(i);
      chk(rd_data == gold_d[i] && rd_state == gold_s[i], "R10 line restored", rd_data, gold_d[i]);
      chk(rd_cn != 2, "R9 tag restored", rd_cn, 0);
    end
    peek(5);
    chk(rd_state == 0, "R10 filled line invalid", rd_state, 0);
    peek(2);
    chk(rd_cn == 1, "R9 oldest tag kept", rd_cn, 1);
  endtask

  task automatic t_after;
    do_op(1, 2, 'hacdc, 1);
    chk(log_count == 1, "R11 logged after recovery", log_count, 1);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin mdl_d[i] = 0; mdl_s[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_first_and_repeat();
    t_fill_xfer();
    t_ckpt_and_full();
    t_validate();
    t_recover();
    t_after();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule